// File: doc/BRIEF.md
# Boot ROM overlay controller

This block decodes a 2 KiB window in a host CPU's 16-bit memory space. The window sits at 0xF000 by default. Out of reset the window serves a fixed boot image. A configuration pin can instead make the window start as RAM. The boot image is computed from each byte's offset, so the block needs no external content file.

Once start-up code has copied what it needs, it writes a control byte to an I/O port. That write turns the image off, and the same addresses then act as ordinary read/write RAM. A second write to the same port can bring the image back. A separate boot request input forces the image back on and announces the restart program counter.

Writes that land on the image are dropped and flagged. Read data is registered, so it appears one cycle after the read strobe.

Top module: `boot_overlay`

## Requirements
- R1: `mem_hit` is high exactly when `mem_addr[15:11]` equals bits 15:11 of the base address (0xF000 by default, so 0xF000 to 0xF7FF). It depends on the address alone and not on the strobes.
- R2: When `rom_sel_cfg` is 1 during reset, window reads return the image. The image byte at offset o = `mem_addr[10:0]` is ((o[7:0] XOR o[10:8]) * 37 + 11) mod 256.
- R3: When `rom_sel_cfg` is 0 during reset, the window starts as RAM. RAM contents are not cleared by reset.
- R4: `mem_rdata` carries the byte of a window read in the cycle after the read strobe. It is 0x00 after any cycle that had no window read.
- R5: While the image is on, a window write leaves the RAM unchanged. Each such write raises `wr_err` for exactly one cycle, the cycle after the write.
- R6: While the image is off, a window write stores `mem_wdata` at offset `mem_addr[10:0]`. Later reads at that offset return the stored byte, and `wr_err` stays low.
- R7: An I/O write to port 0x16 sets the image state from bit 5 of the data: 1 turns the image off and 0 turns it on. The new state applies from the next cycle. Other ports and other data bits have no effect on the image state.
- R8: A boot request turns the image on from the next cycle. In that same next cycle `boot_pc_vld` pulses for one cycle with `boot_pc` = 0xF000. A boot request wins over a control-port write made in the same cycle.
- R9: A window access made in the same cycle as a control-port write uses the image state that held before that write.
- R10: A write outside the window changes no RAM byte and raises no `wr_err`. A read outside the window returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_sel_cfg | input | 1 | Image state loaded at reset (1 = image on) |
| mem_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Registered read data |
| mem_hit | output | 1 | Address falls inside the window |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| boot_req | input | 1 | Boot request |
| boot_pc_vld | output | 1 | One-cycle pulse announcing the restart address |
| boot_pc | output | 16 | Restart program counter |
| wr_err | output | 1 | Pulse for each write dropped by the image |

## Verification
The hardest case to reach is proving that a write dropped by the image left the RAM unchanged. While the image is on, the RAM cannot be seen at all. The stimulus therefore turns the image off, seeds known RAM bytes, and turns the image back on. It then writes to the same offsets and raises a boot request on top of a disable write. Finally it switches the image off again and reads the seeded bytes back. The same route checks the writes made on the control-write cycle and the writes made outside the window.

// File: rtl/boot_overlay.sv
module boot_overlay #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                WIN_BITS  = 11,
  parameter int                PORT_W    = 8,
  parameter logic [ADDR_W-1:0] BASE      = 16'hF000,
  parameter logic [PORT_W-1:0] CTRL_PORT = 8'h16,
  parameter int                DIS_BIT   = 5,
  parameter logic [ADDR_W-1:0] RESTART   = 16'hF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_sel_cfg,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              mem_hit,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              boot_req,
  output logic              boot_pc_vld,
  output logic [ADDR_W-1:0] boot_pc,
  output logic              wr_err
);
  localparam int DEPTH = 1 << WIN_BITS;

  function automatic logic [DATA_W-1:0] rom_byte(input logic [WIN_BITS-1:0] o);
    logic [WIN_BITS-1:0] t;
    logic [7:0] m;
    t = o ^ (o >> 8);
    m = t[7:0] * 8'd37 + 8'd11;
    return DATA_W'(m);
  endfunction

  logic                rom_en;
  logic [DATA_W-1:0]   ram [DEPTH];
  logic [WIN_BITS-1:0] off;
  logic                rd_go, wr_go, ctl_wr;
  logic                unused_io;

  assign off       = mem_addr[WIN_BITS-1:0];
  assign mem_hit   = mem_addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS];
  assign rd_go     = mem_rd & mem_hit;
  assign wr_go     = mem_wr & mem_hit;
  assign ctl_wr    = io_wr && (io_port == CTRL_PORT);
  assign boot_pc   = RESTART;
  assign unused_io = ^io_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)        rom_en <= rom_sel_cfg;
    else if (boot_req) rom_en <= 1'b1;
    else if (ctl_wr)   rom_en <= ~io_wdata[DIS_BIT];
  end

  always_ff @(posedge clk) begin
    if (wr_go && !rom_en) ram[off] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rdata   <= '0;
      wr_err      <= 1'b0;
      boot_pc_vld <= 1'b0;
    end else begin
      mem_rdata   <= rd_go ? (rom_en ? rom_byte(off) : ram[off]) : '0;
      wr_err      <= wr_go & rom_en;
      boot_pc_vld <= boot_req;
    end
  end
endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] CTRL_PORT = 8'h16,
  parameter int                DIS_BIT   = 5,
  parameter logic [ADDR_W-1:0] RESTART   = 16'hF000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_hit,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              io_wr,
  input logic [PORT_W-1:0] io_port,
  input logic [DATA_W-1:0] io_wdata,
  input logic              boot_req,
  input logic              boot_pc_vld,
  input logic [ADDR_W-1:0] boot_pc,
  input logic              wr_err,
  input logic              rom_en
);
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_hit) |=> mem_rdata == '0);

  p_err_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(mem_wr && mem_hit && rom_en));

  p_no_err_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_hit && !rom_en) |=> !wr_err);

  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == CTRL_PORT && io_wdata[DIS_BIT] && !boot_req) |=> !rom_en);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_req && !(io_wr && io_port == CTRL_PORT)) |=> $stable(rom_en));

  p_boot_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |=> (rom_en && boot_pc_vld));

  p_boot_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pc_vld |-> boot_pc == RESTART);
endmodule

bind boot_overlay boot_overlay_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
  .CTRL_PORT(CTRL_PORT), .DIS_BIT(DIS_BIT), .RESTART(RESTART)
) u_chk (.*);

// File: tb/sim_boot_overlay.sv
module sim_boot_overlay;
  logic clk = 1'b0;
  logic rst_n, rom_sel_cfg;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_hit, io_wr;
  logic [7:0] io_port, io_wdata;
  logic boot_req, boot_pc_vld, wr_err;
  logic [15:0] boot_pc;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] r_data;
  logic r_err, r_vld, r_hit;
  logic [15:0] r_pc;

  always #5 clk = ~clk;

  boot_overlay u0 (.*);

  function automatic logic [7:0] img(input int o);
    int m;
    m = ((o & 255) ^ ((o >> 8) & 7)) * 37 + 11;
    return 8'(m & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] wd,
                     input logic iw, input logic [7:0] p, input logic [7:0] iod, input logic bt);
    mem_addr = a; mem_rd = rd; mem_wr = wr; mem_wdata = wd;
    io_wr = iw; io_port = p; io_wdata = iod; boot_req = bt;
    #1 r_hit = mem_hit;
    @(negedge clk);
    r_data = mem_rdata; r_err = wr_err; r_vld = boot_pc_vld; r_pc = boot_pc;
    mem_rd = 0; mem_wr = 0; io_wr = 0; boot_req = 0;
  endtask

  task automatic idle();        cyc(16'h0000, 0, 0, 8'h00, 0, 8'h00, 8'h00, 0); endtask
  task automatic rd(input logic [15:0] a);                  cyc(a, 1, 0, 8'h00, 0, 8'h00, 8'h00, 0); endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d); cyc(a, 0, 1, d, 0, 8'h00, 8'h00, 0); endtask
  task automatic io(input logic [7:0] p, input logic [7:0] d);  cyc(16'h0000, 0, 0, 8'h00, 1, p, d, 0); endtask

  task automatic do_reset(input logic cfg);
    rom_sel_cfg = cfg; rst_n = 0;
    idle(); idle();
    check("R4 reset rdata", {24'b0, r_data}, 0);
    check("R5 reset wr_err", {31'b0, r_err}, 0);
    check("R8 reset boot_pc_vld", {31'b0, r_vld}, 0);
    rst_n = 1;
  endtask

  task automatic t_hit();
    cyc(16'hF000, 0, 0, 0, 0, 0, 0, 0); check("R1 hit F000", {31'b0, r_hit}, 1);
    cyc(16'hF7FF, 0, 0, 0, 0, 0, 0, 0); check("R1 hit F7FF", {31'b0, r_hit}, 1);
    cyc(16'hF800, 0, 0, 0, 0, 0, 0, 0); check("R1 miss F800", {31'b0, r_hit}, 0);
    cyc(16'hEFFF, 1, 0, 0, 0, 0, 0, 0); check("R1 miss EFFF", {31'b0, r_hit}, 0);
    check("R10 outside read zero", {24'b0, r_data}, 0);
  endtask

  task automatic t_rom_reads();
    int offs [4] = '{0, 16'h7FF, 16'h123, 16'h456};
    foreach (offs[i]) begin
      rd(16'hF000 + 16'(offs[i]));
      check("R2 image byte", {24'b0, r_data}, {24'b0, img(offs[i])});
    end
    idle(); check("R4 idle rdata zero", {24'b0, r_data}, 0);
  endtask

  task automatic t_seed_ram();
    io(8'h16, 8'h20);
    wr(16'hF010, 8'h33); check("R6 no err when off", {31'b0, r_err}, 0);
    wr(16'hF7FF, 8'hC4);
    rd(16'hF010); check("R6 readback F010", {24'b0, r_data}, 8'h33);
    rd(16'hF7FF); check("R6 readback F7FF", {24'b0, r_data}, 8'hC4);
  endtask

  task automatic t_discard();
    io(8'h16, 8'h00);
    rd(16'hF010); check("R7 enable restores image", {24'b0, r_data}, {24'b0, img(16'h010)});
    wr(16'hF010, 8'h99); check("R5 err pulse", {31'b0, r_err}, 1);
    idle(); check("R5 err one cycle", {31'b0, r_err}, 0);
    wr(16'hF7FF, 8'h11); check("R5 second err", {31'b0, r_err}, 1);
    io(8'h15, 8'h20);
    io(8'h16, 8'hDF);
    rd(16'hF7FF); check("R7 other port/bits ignored", {24'b0, r_data}, {24'b0, img(16'h7FF)});
    io(8'h16, 8'h20);
    rd(16'hF010); check("R5 RAM unchanged F010", {24'b0, r_data}, 8'h33);
    rd(16'hF7FF); check("R5 RAM unchanged F7FF", {24'b0, r_data}, 8'hC4);
  endtask

  task automatic t_outside();
    wr(16'h7010, 8'h77); check("R10 no err outside", {31'b0, r_err}, 0);
    rd(16'h7010); check("R10 outside read zero", {24'b0, r_data}, 0);
    rd(16'hF010); check("R10 RAM untouched", {24'b0, r_data}, 8'h33);
  endtask

  task automatic t_same_cycle();
    io(8'h16, 8'h00);
    cyc(16'hF010, 1, 0, 0, 1, 8'h16, 8'h20, 0);
    check("R9 read uses old state (image)", {24'b0, r_data}, {24'b0, img(16'h010)});
    rd(16'hF010); check("R9 next read RAM", {24'b0, r_data}, 8'h33);
    cyc(16'hF020, 0, 1, 8'h44, 1, 8'h16, 8'h00, 0);
    check("R9 write on enable cycle no err", {31'b0, r_err}, 0);
    wr(16'hF020, 8'h55); check("R9 image on after", {31'b0, r_err}, 1);
    io(8'h16, 8'h20);
    rd(16'hF020); check("R9 write stored", {24'b0, r_data}, 8'h44);
  endtask

  task automatic t_boot();
    cyc(16'h0000, 0, 0, 0, 1, 8'h16, 8'h20, 1);
    check("R8 pc valid", {31'b0, r_vld}, 1);
    check("R8 pc value", {16'b0, r_pc}, 16'hF000);
    rd(16'hF010); check("R8 image on after boot", {24'b0, r_data}, {24'b0, img(16'h010)});
    check("R8 pulse one cycle", {31'b0, r_vld}, 0);
  endtask

  task automatic t_ram_reset();
    do_reset(1'b0);
    rd(16'hF010); check("R3 RAM at reset, kept", {24'b0, r_data}, 8'h33);
    wr(16'hF030, 8'h5A); check("R3 no err", {31'b0, r_err}, 0);
    rd(16'hF030); check("R3 RAM write", {24'b0, r_data}, 8'h5A);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mem_addr = 0; mem_rd = 0; mem_wr = 0; mem_wdata = 0;
    io_wr = 0; io_port = 0; io_wdata = 0; boot_req = 0;
    rst_n = 0; rom_sel_cfg = 1;
    @(negedge clk);
    do_reset(1'b1);
    t_hit();
    t_rom_reads();
    t_seed_ram();
    t_discard();
    t_outside();
    t_same_cycle();
    t_boot();
    t_ram_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule